// File: doc/BRIEF.md
# Cubic INL Correction Engine

This block sits in the digital path that feeds a 14-bit DAC. Its job is to cancel the DAC's integral non-linearity as the DAC runs. The INL is modelled as a cubic in the input code, and four signed coefficients describe that cubic. A characterisation step that runs off-line writes the coefficients in. For every code that streams in, the engine evaluates the cubic in a fixed pipeline. It then negates, rounds and saturates the result into a signed 6-bit word for a small dithering DAC, whose analog output is added to the main DAC's output. The code itself leaves the block delayed by the same number of stages, so the code and its correction reach the two converters together.

Coefficients are written one at a time into a shadow bank. A single commit strobe copies the whole shadow bank into the active bank. Every sample captures a snapshot of the active bank on entry and carries it down the pipe. As a result, no output is ever computed from a mix of an old set and a new set. A bypass input zeroes the correction for the samples it accompanies.

Top module: `inl_cubic_corrector`

## Requirements
- R1: Reset values. While reset is held and right after it, `out_valid_o`, `out_code_o` and `corr_o` are all zero. Both coefficient banks reset to zero, so every sample gets a correction of 0 until a set is committed.
- R2: Latency. A sample accepted on a clock edge with `in_valid_i` high appears on `out_valid_o` and `out_code_o` exactly 5 clock edges later, unchanged and in the order it arrived.
- R3: Evaluation. The normalised code is u = x / 2^CODE_W. The engine evaluates y = c0 + c1·u + c2·u² + c3·u³ with Horner's rule, in units of 2^-FRAC_W main-DAC LSB. Each step computes acc' = floor(acc·x / 2^CODE_W) + c_next, starting from acc = c3 and adding c2, then c1, then c0.
- R4: Quantisation. The correction is in units of 2^-CORR_FRAC_W main-DAC LSB and equals floor((-y + 2^(S-1)) / 2^S), where S = FRAC_W - CORR_FRAC_W. This means a tie rounds toward +infinity: with S = 9, y = -256 gives 1 and y = +256 gives 0.
- R5: Saturation. A rounded correction above +31 leaves as +31, and one below -32 leaves as -32 (two's complement on `corr_o`).
- R6: Shadow writes. A write with `coef_wr_i` high stores `coef_data_i` into the shadow slot chosen by `coef_sel_i` (0 = c0, 1 = c1, 2 = c2, 3 = c3). A shadow write has no effect on any correction until a commit.
- R7: Atomic commit. A commit copies all four shadow slots into the active bank at once. A sample accepted on the same edge as the commit, or on any earlier edge, uses the old set. A sample accepted on any later edge uses the new set. If a write and a commit fall on the same edge, the commit copies the shadow contents from before that write.
- R8: Bypass. A sample accepted while `bypass_i` is high leaves with `corr_o` = 0, and its code still passes through unchanged.
- R9: Hold. On edges where no valid sample leaves the pipe, `out_valid_o` is low and `out_code_o` and `corr_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_wr_i | input | 1 | Write strobe for a shadow coefficient |
| coef_sel_i | input | 2 | Shadow slot selector (0..3 = c0..c3) |
| coef_data_i | input | COEF_W | Signed coefficient value, FRAC_W fractional bits |
| coef_commit_i | input | 1 | Copies the shadow bank into the active bank |
| bypass_i | input | 1 | Forces a zero correction for the accepted sample |
| in_valid_i | input | 1 | Input code is valid |
| in_code_i | input | CODE_W | Unsigned DAC input code |
| out_valid_o | output | 1 | Output code and correction are valid |
| out_code_o | output | CODE_W | Code to the main DAC, delayed to match the correction |
| corr_o | output | CORR_W | Signed correction word for the dithering DAC |

## Verification
The bench builds the block with its default parameters: a 14-bit code, 20-bit coefficients with 12 fractional bits, and a 6-bit correction in eighths of an LSB. With these values the full code range can be driven directly, including the end codes 0 and 16383. A coefficient near full scale pushes the correction past both saturation limits. Constant terms of ±256 land exactly on the rounding tie. Commits are issued both between samples and in the middle of a back-to-back stream, so the old-set and new-set boundary is exercised on both sides.

// File: rtl/inl_corr_pkg.sv
`timescale 1ns/1ps
package inl_corr_pkg;
    localparam int DEF_CODE_W      = 14;
    localparam int DEF_COEF_W      = 20;
    localparam int DEF_FRAC_W      = 12;
    localparam int DEF_CORR_FRAC_W = 3;
    localparam int DEF_CORR_W      = 6;
    localparam int N_COEF          = 4;

    // Slot order of the coefficient bank: constant term first.
    typedef enum logic [1:0] {
        SLOT_C0 = 2'd0,
        SLOT_C1 = 2'd1,
        SLOT_C2 = 2'd2,
        SLOT_C3 = 2'd3
    } coef_slot_e;
endpackage

// File: rtl/inl_coef_bank.sv
`timescale 1ns/1ps
module inl_coef_bank
    import inl_corr_pkg::*;
#(
    parameter int COEF_W = DEF_COEF_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [1:0]                     sel_i,
    input  logic [COEF_W-1:0]              data_i,
    input  logic                           commit_i,
    output logic [N_COEF-1:0][COEF_W-1:0]  active_o
);
    typedef struct packed {
        logic [N_COEF-1:0][COEF_W-1:0] shadow;
        logic [N_COEF-1:0][COEF_W-1:0] active;
    } bank_t;

    bank_t      bank_d, bank_q;
    coef_slot_e slot_w;

    assign slot_w = coef_slot_e'(sel_i);

    always_comb begin
        bank_d = bank_q;
        // commit takes the shadow as it was before this edge's write
        if (commit_i) begin
            bank_d.active = bank_q.shadow;
        end
        if (wr_i) begin
            bank_d.shadow[slot_w] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_o = bank_q.active;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit_i) |-> $stable(active_o)); // R6
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit_i) |-> (active_o == $past(bank_q.shadow))); // R7
endmodule

// File: rtl/inl_horner_step.sv
`timescale 1ns/1ps
module inl_horner_step
    import inl_corr_pkg::*;
#(
    parameter int CODE_W  = DEF_CODE_W,
    parameter int COEF_W  = DEF_COEF_W,
    parameter int ACC_W   = DEF_COEF_W + 2,
    parameter int ADD_IDX = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid_i,
    input  logic                           in_bypass_i,
    input  logic [CODE_W-1:0]              in_code_i,
    input  logic signed [ACC_W-1:0]        in_acc_i,
    input  logic [N_COEF-1:0][COEF_W-1:0]  in_coefs_i,
    output logic                           out_valid_o,
    output logic                           out_bypass_o,
    output logic [CODE_W-1:0]              out_code_o,
    output logic signed [ACC_W-1:0]        out_acc_o,
    output logic [N_COEF-1:0][COEF_W-1:0]  out_coefs_o
);
    localparam int PROD_W = ACC_W + CODE_W + 1;
    localparam int TERMS  = N_COEF - ADD_IDX;
    localparam logic signed [ACC_W:0] BOUND = (ACC_W+1)'(TERMS * (2 ** (COEF_W - 1)));

    typedef struct packed {
        logic                          valid;
        logic                          bypass;
        logic [CODE_W-1:0]             code;
        logic signed [ACC_W-1:0]       acc;
        logic [N_COEF-1:0][COEF_W-1:0] coefs;
    } step_t;

    step_t                    st_d, st_q;
    logic signed [PROD_W-1:0] prod_w;
    logic signed [PROD_W-1:0] scaled_w;
    logic signed [ACC_W-1:0]  addend_w;

    always_comb begin
        prod_w   = in_acc_i * $signed({1'b0, in_code_i});
        scaled_w = prod_w >>> CODE_W;
        addend_w = ACC_W'($signed(in_coefs_i[ADD_IDX]));
        st_d.valid  = in_valid_i;
        st_d.bypass = in_bypass_i;
        st_d.code   = in_code_i;
        st_d.acc    = scaled_w[ACC_W-1:0] + addend_w;
        st_d.coefs  = in_coefs_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o  = st_q.valid;
    assign out_bypass_o = st_q.bypass;
    assign out_code_o   = st_q.code;
    assign out_acc_o    = st_q.acc;
    assign out_coefs_o  = st_q.coefs;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (($signed(out_acc_o) <= BOUND) && ($signed(out_acc_o) >= -BOUND))); // R3
endmodule

// File: rtl/inl_quantizer.sv
`timescale 1ns/1ps
module inl_quantizer
    import inl_corr_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int ACC_W       = DEF_COEF_W + 2,
    parameter int FRAC_W      = DEF_FRAC_W,
    parameter int CORR_FRAC_W = DEF_CORR_FRAC_W,
    parameter int CORR_W      = DEF_CORR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic                    in_bypass_i,
    input  logic [CODE_W-1:0]       in_code_i,
    input  logic signed [ACC_W-1:0] in_acc_i,
    output logic                    valid_o,
    output logic [CODE_W-1:0]       code_o,
    output logic [CORR_W-1:0]       corr_o
);
    localparam int SHIFT = FRAC_W - CORR_FRAC_W;
    localparam int WIDE  = ACC_W + 2;
    localparam logic signed [WIDE-1:0] HALF = WIDE'(2 ** (SHIFT - 1));
    localparam logic signed [WIDE-1:0] HI   = WIDE'(2 ** (CORR_W - 1) - 1);
    localparam logic signed [WIDE-1:0] LO   = WIDE'(-(2 ** (CORR_W - 1)));

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [CORR_W-1:0] corr;
    } out_t;

    out_t                   out_d, out_q;
    logic signed [WIDE-1:0] neg_w;
    logic signed [WIDE-1:0] rnd_w;
    logic [CORR_W-1:0]      sat_w;

    always_comb begin
        neg_w = HALF - WIDE'(in_acc_i);
        rnd_w = neg_w >>> SHIFT;
        if (rnd_w > HI) begin
            sat_w = HI[CORR_W-1:0];
        end else if (rnd_w < LO) begin
            sat_w = LO[CORR_W-1:0];
        end else begin
            sat_w = rnd_w[CORR_W-1:0];
        end

        out_d       = out_q;
        out_d.valid = in_valid_i;
        if (in_valid_i) begin
            out_d.code = in_code_i;
            out_d.corr = in_bypass_i ? '0 : sat_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.valid;
    assign code_o  = out_q.code;
    assign corr_o  = out_q.corr;

    AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid_i && in_bypass_i) |-> (corr_o == '0)); // R8
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid_i && !in_bypass_i && (rnd_w > HI)) |-> (corr_o == HI[CORR_W-1:0])); // R5
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid_i && !in_bypass_i && (rnd_w < LO)) |-> (corr_o == LO[CORR_W-1:0])); // R5
endmodule

// File: rtl/inl_cubic_corrector.sv
`timescale 1ns/1ps
module inl_cubic_corrector
    import inl_corr_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int COEF_W      = DEF_COEF_W,
    parameter int FRAC_W      = DEF_FRAC_W,
    parameter int CORR_FRAC_W = DEF_CORR_FRAC_W,
    parameter int CORR_W      = DEF_CORR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_wr_i,
    input  logic [1:0]        coef_sel_i,
    input  logic [COEF_W-1:0] coef_data_i,
    input  logic              coef_commit_i,
    input  logic              bypass_i,
    input  logic              in_valid_i,
    input  logic [CODE_W-1:0] in_code_i,
    output logic              out_valid_o,
    output logic [CODE_W-1:0] out_code_o,
    output logic [CORR_W-1:0] corr_o
);
    localparam int ACC_W   = COEF_W + 2;
    localparam int N_STEPS = N_COEF - 1;
    localparam int LAT     = N_STEPS + 2;

    typedef struct packed {
        logic                          valid;
        logic                          bypass;
        logic [CODE_W-1:0]             code;
        logic signed [ACC_W-1:0]       acc;
        logic [N_COEF-1:0][COEF_W-1:0] coefs;
    } entry_t;

    logic [N_COEF-1:0][COEF_W-1:0] active_w;
    entry_t                        ent_d, ent_q;

    logic                          pv [N_STEPS+1];
    logic                          pb [N_STEPS+1];
    logic [CODE_W-1:0]             pc [N_STEPS+1];
    logic signed [ACC_W-1:0]       pa [N_STEPS+1];
    logic [N_COEF-1:0][COEF_W-1:0] pk [N_STEPS+1];

    inl_coef_bank #(
        .COEF_W (COEF_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (coef_wr_i),
        .sel_i    (coef_sel_i),
        .data_i   (coef_data_i),
        .commit_i (coef_commit_i),
        .active_o (active_w)
    );

    // Entry stage: snapshot the whole active set with the sample.
    always_comb begin
        ent_d.valid  = in_valid_i;
        ent_d.bypass = bypass_i;
        ent_d.code   = in_code_i;
        ent_d.acc    = ACC_W'($signed(active_w[N_COEF-1]));
        ent_d.coefs  = active_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign pv[0] = ent_q.valid;
    assign pb[0] = ent_q.bypass;
    assign pc[0] = ent_q.code;
    assign pa[0] = ent_q.acc;
    assign pk[0] = ent_q.coefs;

    for (genvar g = 0; g < N_STEPS; g++) begin : g_step
        inl_horner_step #(
            .CODE_W  (CODE_W),
            .COEF_W  (COEF_W),
            .ACC_W   (ACC_W),
            .ADD_IDX (N_STEPS - 1 - g)
        ) step_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .in_valid_i   (pv[g]),
            .in_bypass_i  (pb[g]),
            .in_code_i    (pc[g]),
            .in_acc_i     (pa[g]),
            .in_coefs_i   (pk[g]),
            .out_valid_o  (pv[g+1]),
            .out_bypass_o (pb[g+1]),
            .out_code_o   (pc[g+1]),
            .out_acc_o    (pa[g+1]),
            .out_coefs_o  (pk[g+1])
        );
    end

    inl_quantizer #(
        .CODE_W      (CODE_W),
        .ACC_W       (ACC_W),
        .FRAC_W      (FRAC_W),
        .CORR_FRAC_W (CORR_FRAC_W),
        .CORR_W      (CORR_W)
    ) quant_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (pv[N_STEPS]),
        .in_bypass_i (pb[N_STEPS]),
        .in_code_i   (pc[N_STEPS]),
        .in_acc_i    (pa[N_STEPS]),
        .valid_o     (out_valid_o),
        .code_o      (out_code_o),
        .corr_o      (corr_o)
    );

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == $past(in_valid_i, 5)); // R2
    AST_CODE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_code_o == $past(in_code_i, 5))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> ($stable(out_code_o) && $stable(corr_o))); // R9

    initial begin
        if (LAT != 5) $display("latency constant differs from 5");
    end
endmodule

// File: tb/inl_cubic_corrector_tb_top.sv
`timescale 1ns/1ps
module inl_cubic_corrector_tb_top;
    localparam int CODE_W = 14;
    localparam int COEF_W = 20;
    localparam int CORR_W = 6;
    localparam int SHIFT  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coef_wr = 1'b0;
    logic [1:0]        coef_sel = '0;
    logic [COEF_W-1:0] coef_data = '0;
    logic              coef_commit = 1'b0;
    logic              bypass = 1'b0;
    logic              in_valid = 1'b0;
    logic [CODE_W-1:0] in_code = '0;
    logic              out_valid;
    logic [CODE_W-1:0] out_code;
    logic [CORR_W-1:0] corr;

    int     total = 0;
    int     bad = 0;
    longint shadow_m [4];
    longint active_m [4];
    int     exp_code_q [$];
    int     exp_corr_q [$];
    string  exp_tag_q [$];
    int unsigned lfsr = 32'h1234_5678;
    bit     done = 1'b0;

    always #4 clk = ~clk;

    inl_cubic_corrector dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .coef_wr_i     (coef_wr),
        .coef_sel_i    (coef_sel),
        .coef_data_i   (coef_data),
        .coef_commit_i (coef_commit),
        .bypass_i      (bypass),
        .in_valid_i    (in_valid),
        .in_code_i     (in_code),
        .out_valid_o   (out_valid),
        .out_code_o    (out_code),
        .corr_o        (corr)
    );

    // Expected correction straight from R3, R4, R5, R8.
    function automatic int model(int code, longint c [4], bit byp);
        longint acc = c[3];
        longint r;
        for (int i = 2; i >= 0; i--) begin
            acc = ((acc * code) >>> CODE_W) + c[i];
        end
        r = ((-acc) + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
        if (r > 31) r = 31;
        if (r < -32) r = -32;
        if (byp) r = 0;
        return int'(r);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(bit wr, int sel, longint data, bit cm, bit vld, int code, bit byp, string tag);
        coef_wr     = wr;
        coef_sel    = sel[1:0];
        coef_data   = COEF_W'(data);
        coef_commit = cm;
        in_valid    = vld;
        in_code     = code[CODE_W-1:0];
        bypass      = byp;
        if (vld) begin
            exp_code_q.push_back(code);
            exp_corr_q.push_back(model(code, active_m, byp));
            exp_tag_q.push_back(tag);
        end
        if (cm) active_m = shadow_m;
        if (wr) shadow_m[sel] = data;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic load_set(longint c0, longint c1, longint c2, longint c3);
        drive(1, 0, c0, 0, 0, 0, 0, "");
        drive(1, 1, c1, 0, 0, 0, 0, "");
        drive(1, 2, c2, 0, 0, 0, 0, "");
        drive(1, 3, c3, 0, 0, 0, 0, "");
        drive(0, 0, 0, 1, 0, 0, 0, "");
    endtask

    function automatic int next_code();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return int'(lfsr % 16384);
    endfunction

    // Monitor: pops the scoreboard whenever a result leaves.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_code_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R2 actual=unexpected output expected=none");
            end else begin
                string t;
                int ec, er;
                ec = exp_code_q.pop_front();
                er = exp_corr_q.pop_front();
                t  = exp_tag_q.pop_front();
                check({t, " code R2"}, int'(out_code), ec);
                check({t, " corr"}, int'($signed(corr)), er);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            shadow_m[i] = 0;
            active_m[i] = 0;
        end
        repeat (5) @(negedge clk);
        // R1: reset values
        check("R1 valid", int'(out_valid), 0);
        check("R1 code", int'(out_code), 0);
        check("R1 corr", int'(corr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after", int'(out_valid), 0);

        // R1: zero coefficients give zero correction
        drive(0, 0, 0, 0, 1, 16383, 0, "R1");
        drive(0, 0, 0, 0, 1, 5000, 0, "R1");
        idle(7);

        // R4: constant term, one LSB and the two ties
        load_set(4096, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 100, 0, "R4 one-lsb");
        idle(6);
        load_set(-256, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 200, 0, "R4 tie-neg");
        idle(6);
        load_set(256, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 300, 0, "R4 tie-pos");
        idle(6);

        // R3: full cubic, end codes, midpoint and a pseudo-random stream
        load_set(-1500, 6000, -9000, 5000);
        drive(0, 0, 0, 0, 1, 0, 0, "R3 code0");
        drive(0, 0, 0, 0, 1, 16383, 0, "R3 codemax");
        drive(0, 0, 0, 0, 1, 8192, 0, "R3 mid");
        for (int i = 0; i < 40; i++) drive(0, 0, 0, 0, 1, next_code(), 0, "R3 stream");
        idle(6);
        load_set(2000, -7000, 12000, -4000);
        for (int i = 0; i < 40; i++) begin
            drive(0, 0, 0, 0, (i % 3) != 1, next_code(), 0, "R3 gaps");
        end
        idle(6);

        // R5: saturation on both sides
        load_set(524287, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 40, 0, "R5 low");
        idle(6);
        load_set(-524288, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 41, 0, "R5 high");
        idle(6);
        load_set(0, 0, 0, 524287);
        drive(0, 0, 0, 0, 1, 16383, 0, "R5 cubic");
        drive(0, 0, 0, 0, 1, 1000, 0, "R5 cubic small");
        idle(6);

        // R6: shadow writes without a commit leave output on the old set
        load_set(4096, 0, 0, 0);
        drive(1, 0, -8192, 0, 1, 700, 0, "R6");
        drive(1, 3, 300000, 0, 1, 16000, 0, "R6");
        drive(0, 0, 0, 0, 1, 9000, 0, "R6");
        idle(6);

        // R7: commit in the middle of a back-to-back stream
        drive(1, 1, 20000, 0, 1, 12000, 0, "R7 before");
        drive(0, 0, 0, 1, 1, 12001, 0, "R7 same-edge");
        drive(1, 2, -50000, 0, 1, 12002, 0, "R7 after");
        drive(1, 0, 1000, 1, 1, 12003, 0, "R7 write+commit");
        drive(0, 0, 0, 0, 1, 12004, 0, "R7 after2");
        idle(6);

        // R8: bypass zeroes the correction, code passes
        load_set(12000, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 321, 1, "R8 bypass");
        drive(0, 0, 0, 0, 1, 322, 0, "R8 normal");
        drive(0, 0, 0, 0, 1, 323, 1, "R8 bypass");
        idle(6);

        // R9: outputs hold while no sample leaves
        begin
            int hold_code, hold_corr;
            hold_code = int'(out_code);
            hold_corr = int'(corr);
            idle(4);
            check("R9 valid", int'(out_valid), 0);
            check("R9 code", int'(out_code), hold_code);
            check("R9 corr", int'(corr), hold_corr);
            check("R9 last code", hold_code, 323);
        end

        idle(4);
        check("R2 drained", exp_code_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule